// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns characters into an asynchronous serial bit stream on a single output line. Each character frame has a low start bit, then 5 to 8 data bits sent least significant bit first. An address bit and a parity bit can follow the data. The frame closes with one or two high stop bits. The start and stop bits are generated internally. Characters arrive on a valid/ready interface that carries the data byte and, separately, the address bit.

Bit timing comes from an external one-cycle `baud_tick` pulse. Each transmitted bit lasts exactly one tick interval. A short pulse on a command input queues a break or a preamble:

- A break drives the line low for one character time and then high for one bit.
- A preamble holds the line high for one character time before the next character.

While the `freeze` level is high, the transmitter stops at the next bit boundary and holds the line. When `freeze` falls, transmission resumes from the bit where it stopped.

Top module: `serial_char_tx`

## Requirements
- R1: After reset, and whenever nothing is being sent, `tx_line` is high. A new item (character, break or preamble) starts only on an unfrozen `baud_tick` where the line is idle or the final bit of the current item is ending. `in_ready` is high only in such a cycle.
- R2: A character frame is one low start bit, then `5 + cfg_len_code` data bits taken from `in_data` least significant bit first (code 0 means 5 bits, code 3 means 8 bits), then stop bits at logic high.
- R3: When `cfg_addr_en` is 1, the value of `in_addr` is sent as one extra bit right after the last data bit.
- R4: When `cfg_par_en` is 1, a parity bit follows the data bits and the address bit. It covers the sent data bits plus the address bit when that bit is enabled. With `cfg_par_odd` = 0 the count of ones is even; with `cfg_par_odd` = 1 it is odd.
- R5: `cfg_two_stop` = 0 gives one stop bit; `cfg_two_stop` = 1 gives two.
- R6: A `brk_req` pulse queues a break. The break drives the line low for N bit times, where N is the full frame length under the current format, and then high for one bit time.
- R7: A `pre_req` pulse queues a preamble. The preamble holds the line high for N bit times, after which a waiting character is sent.
- R8: When the line becomes free and several items are pending, a queued break goes first, then a queued preamble, then a valid character. A command pulse stays pending until it is served.
- R9: While `freeze` is high, ticks are ignored. The bit being sent is held on the line and nothing new is accepted. After `freeze` falls, the remaining bits follow with no bit lost or repeated.
- R10: Characters offered back to back are sent with no idle bit between the last stop bit and the next start bit. Every bit lasts exactly one tick interval.
- R11: The format inputs are sampled when an item starts. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| freeze | input | 1 | Level that holds transmission at a bit boundary |
| cfg_len_code | input | LEN_W | Data length code, 5 + code bits |
| cfg_addr_en | input | 1 | Enable the address bit |
| cfg_par_en | input | 1 | Enable the parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| brk_req | input | 1 | Pulse that queues a break |
| pre_req | input | 1 | Pulse that queues a preamble |
| in_valid | input | 1 | Character available |
| in_ready | output | 1 | Character accepted this cycle when valid |
| in_data | input | MAX_DATA | Character data bits |
| in_addr | input | 1 | Address bit value for this character |
| tx_line | output | 1 | Serial output line |

## Verification
Two pairs of events are made to land on the same tick.

- **Break request against a waiting character.** A break request is pulsed in the same cycle that a character becomes valid. The bench then expects the whole break, its trailing high bit and only after that the character.
- **Freeze against the end of a stop bit.** A freeze is raised during the last stop bit of a frame while the next character is already valid. The line must stay high for the whole frozen span, and the new start bit must appear on the first tick after release.

In both cases a bit-by-bit scoreboard compares every sampled bit of the line against the frame sequence computed in the bench.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_CHAR  = 2'd1,
    SRC_BREAK = 2'd2,
    SRC_PRE   = 2'd3
  } src_t;
endpackage

// File: rtl/sct_frame_build.sv
// Builds the character frame and the break pattern from the live format inputs.
module sct_frame_build #(
  parameter int MAX_DATA = 8,
  parameter int LEN_W    = 2,
  parameter int SW       = 14,
  parameter int CW       = 4
) (
  input  logic [MAX_DATA-1:0] data,
  input  logic                addr,
  input  logic [LEN_W-1:0]    len_code,
  input  logic                addr_en,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                two_stop,
  output logic [SW-1:0]       char_vec,
  output logic [SW-1:0]       brk_vec,
  output logic [CW-1:0]       nbits
);
  localparam int MIN_DATA = MAX_DATA - (2 ** LEN_W) + 1;

  logic [CW-1:0] len;
  logic [CW-1:0] pos;
  logic          par;

  always_comb begin
    len = CW'(MIN_DATA) + CW'(len_code);
    par = par_odd;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (CW'(i) < len) par = par ^ data[i];
    end
    if (addr_en) par = par ^ addr;

    char_vec    = '1;
    char_vec[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (CW'(i) < len) char_vec[1 + i] = data[i];
    end
    pos = len + CW'(1);
    if (addr_en) begin
      char_vec[pos] = addr;
      pos = pos + CW'(1);
    end
    if (par_en) begin
      char_vec[pos] = par;
      pos = pos + CW'(1);
    end
    pos   = pos + (two_stop ? CW'(2) : CW'(1));
    nbits = pos;

    brk_vec      = '0;
    brk_vec[pos] = 1'b1;
  end
endmodule

// File: rtl/sct_cmd_pending.sv
// Holds break and preamble requests until the sequencer takes them.
module sct_cmd_pending (
  input  logic clk,
  input  logic rst,
  input  logic brk_req,
  input  logic pre_req,
  input  logic take_brk,
  input  logic take_pre,
  output logic brk_pend,
  output logic pre_pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      brk_pend <= 1'b0;
      pre_pend <= 1'b0;
    end else begin
      brk_pend <= (brk_pend & ~take_brk) | brk_req;
      pre_pend <= (pre_pend & ~take_pre) | pre_req;
    end
  end

  // R8
  brk_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (brk_pend && !take_brk) |=> brk_pend);

  // R8
  pre_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (pre_pend && !take_pre) |=> pre_pend);
endmodule

// File: rtl/sct_shift_out.sv
// Output shift register with a remaining-bit counter and a registered line.
module sct_shift_out #(
  parameter int SW = 14,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          load,
  input  logic [SW-1:0] load_vec,
  input  logic [CW-1:0] load_n,
  output logic          free,
  output logic          txd
);
  logic [SW-1:0] sh;
  logic [CW-1:0] cnt;

  assign free = (cnt <= CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '1;
      cnt <= '0;
      txd <= 1'b1;
    end else if (step) begin
      if (free) begin
        if (load) begin
          txd <= load_vec[0];
          sh  <= {1'b1, load_vec[SW-1:1]};
          cnt <= load_n;
        end else begin
          txd <= 1'b1;
          sh  <= '1;
          cnt <= '0;
        end
      end else begin
        txd <= sh[0];
        sh  <= {1'b1, sh[SW-1:1]};
        cnt <= cnt - CW'(1);
      end
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> txd);

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(SW));

  // R10
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt));
endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx #(
  parameter int MAX_DATA = 8,
  parameter int LEN_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                baud_tick,
  input  logic                freeze,
  input  logic [LEN_W-1:0]    cfg_len_code,
  input  logic                cfg_addr_en,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  input  logic                brk_req,
  input  logic                pre_req,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MAX_DATA-1:0] in_data,
  input  logic                in_addr,
  output logic                tx_line
);
  import sct_pkg::*;

  localparam int SW = MAX_DATA + 6;
  localparam int CW = $clog2(SW + 1);

  logic          step;
  logic          free;
  logic          brk_pend, pre_pend;
  logic          take_brk, take_pre, take_chr, load;
  logic [SW-1:0] char_vec, brk_vec, load_vec;
  logic [CW-1:0] nbits, load_n;
  src_t          src;

  sct_frame_build #(.MAX_DATA(MAX_DATA), .LEN_W(LEN_W), .SW(SW), .CW(CW)) u_frame (
    .data(in_data), .addr(in_addr), .len_code(cfg_len_code),
    .addr_en(cfg_addr_en), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .two_stop(cfg_two_stop), .char_vec(char_vec), .brk_vec(brk_vec),
    .nbits(nbits)
  );

  sct_cmd_pending u_cmd (
    .clk(clk), .rst(rst), .brk_req(brk_req), .pre_req(pre_req),
    .take_brk(take_brk), .take_pre(take_pre),
    .brk_pend(brk_pend), .pre_pend(pre_pend)
  );

  assign step     = baud_tick & ~freeze;
  assign take_brk = step & free & brk_pend;
  assign take_pre = step & free & ~brk_pend & pre_pend;
  assign in_ready = step & free & ~brk_pend & ~pre_pend;
  assign take_chr = in_ready & in_valid;
  assign load     = take_brk | take_pre | take_chr;

  always_comb begin
    if (take_brk)      src = SRC_BREAK;
    else if (take_pre) src = SRC_PRE;
    else if (take_chr) src = SRC_CHAR;
    else               src = SRC_NONE;
    case (src)
      SRC_BREAK: begin load_vec = brk_vec; load_n = nbits + CW'(1); end
      SRC_PRE:   begin load_vec = '1;      load_n = nbits;          end
      default:   begin load_vec = char_vec; load_n = nbits;         end
    endcase
  end

  sct_shift_out #(.SW(SW), .CW(CW)) u_shift (
    .clk(clk), .rst(rst), .step(step), .load(load), .load_vec(load_vec),
    .load_n(load_n), .free(free), .txd(tx_line)
  );

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(tx_line));

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    take_chr |=> !tx_line);

  // R6
  break_low_chk: assert property (@(posedge clk) disable iff (rst)
    take_brk |=> !tx_line);

  // R7
  preamble_high_chk: assert property (@(posedge clk) disable iff (rst)
    take_pre |=> tx_line);

  // R8
  single_take_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_brk, take_pre, take_chr}));
endmodule

// File: tb/tb_serial_char_tx.sv
module tb_serial_char_tx;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic       baud_tick;
  logic       freeze = 1'b0;
  logic [1:0] cfg_len_code = 2'd3;
  logic       cfg_addr_en = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       brk_req = 1'b0, pre_req = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_addr = 1'b0;
  logic       tx_line;
  int         phase;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) phase <= 0;
    else     phase <= (phase == DIV - 1) ? 0 : phase + 1;
  end
  assign baud_tick = !rst && (phase == DIV - 1);

  serial_char_tx dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .freeze(freeze),
    .cfg_len_code(cfg_len_code), .cfg_addr_en(cfg_addr_en),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .brk_req(brk_req), .pre_req(pre_req),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_addr(in_addr), .tx_line(tx_line)
  );

  bit    exp_q[$];
  string tag_q[$];
  int    compared = 0;
  int    mismatched = 0;
  logic  last_line = 1'b1;

  task automatic check(logic act, logic exp, string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: tx_line actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int frame_len();
    return 1 + 5 + int'(cfg_len_code) + int'(cfg_addr_en) + int'(cfg_par_en) + (cfg_two_stop ? 2 : 1);
  endfunction

  task automatic push_bit(bit b, string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic push_char(logic [7:0] d, logic a, string tag);
    int  len;
    bit  p;
    len = 5 + int'(cfg_len_code);
    p = cfg_par_odd;
    push_bit(1'b0, tag);
    for (int i = 0; i < len; i++) begin
      push_bit(d[i], tag);
      p = p ^ d[i];
    end
    if (cfg_addr_en) begin
      push_bit(a, tag);
      p = p ^ a;
    end
    if (cfg_par_en) push_bit(p, tag);
    push_bit(1'b1, tag);
    if (cfg_two_stop) push_bit(1'b1, tag);
  endtask

  // Driver: offer a character and queue its bits when it is accepted.
  task automatic send_char(logic [7:0] d, logic a, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_addr  = a;
    while (!in_ready) @(negedge clk);
    push_char(d, a, tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic to_phase(int ph);
    @(negedge clk);
    while (phase != ph) @(negedge clk);
  endtask

  task automatic pulse_cmd(bit is_brk, string tag);
    int n;
    to_phase(2);
    if (is_brk) brk_req = 1'b1; else pre_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    pre_req = 1'b0;
    n = frame_len();
    for (int i = 0; i < n; i++) push_bit(!is_brk, tag);
    if (is_brk) push_bit(1'b1, tag);
  endtask

  task automatic set_freeze(logic v);
    to_phase(2);
    freeze = v;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2 * DIV) @(negedge clk);
  endtask

  // Monitor: one sample per bit time, one cycle after the bit boundary.
  always @(negedge clk) begin
    if (!rst && phase == 1) begin
      if (freeze) begin
        check(tx_line, last_line, "R9");
      end else if (exp_q.size() > 0) begin
        bit    b;
        string t;
        b = exp_q.pop_front();
        t = tag_q.pop_front();
        check(tx_line, b, t);
      end else begin
        check(tx_line, 1'b1, "R1");
      end
      last_line = tx_line;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check(tx_line, 1'b1, "R1");
    rst = 1'b0;
    repeat (3 * DIV) @(negedge clk);
    check(tx_line, 1'b1, "R1");

    // R2: 8 data bits, lsb first, one stop
    send_char(8'hA5, 1'b0, "R2");
    drain();
    // R2: 5-bit length ignores upper data bits
    cfg_len_code = 2'd0;
    send_char(8'hF3, 1'b0, "R2");
    drain();
    // R4: 7 bits with even parity, then odd parity
    cfg_len_code = 2'd2;
    cfg_par_en = 1'b1;
    send_char(8'h5B, 1'b0, "R4");
    drain();
    cfg_par_odd = 1'b1;
    send_char(8'h5B, 1'b0, "R4");
    drain();
    // R3: address bit included in parity
    cfg_len_code = 2'd3;
    cfg_addr_en = 1'b1;
    send_char(8'h81, 1'b1, "R3");
    drain();
    cfg_par_odd = 1'b0;
    send_char(8'h81, 1'b0, "R3");
    drain();
    // R5: two stop bits
    cfg_addr_en = 1'b0;
    cfg_par_en = 1'b0;
    cfg_two_stop = 1'b1;
    send_char(8'h0F, 1'b0, "R5");
    drain();
    cfg_two_stop = 1'b0;
    // R10: back-to-back characters, no idle gap
    send_char(8'h33, 1'b0, "R10");
    send_char(8'hCC, 1'b0, "R10");
    send_char(8'h01, 1'b0, "R10");
    drain();
    // R6: break then a character
    pulse_cmd(1'b1, "R6");
    send_char(8'h77, 1'b0, "R6");
    drain();
    // R7: preamble then a character
    pulse_cmd(1'b0, "R7");
    send_char(8'h96, 1'b0, "R7");
    drain();
    // R8: break request and a valid character in the same cycle
    to_phase(2);
    brk_req  = 1'b1;
    in_valid = 1'b1;
    in_data  = 8'h5A;
    in_addr  = 1'b0;
    @(negedge clk);
    brk_req = 1'b0;
    for (int i = 0; i < frame_len(); i++) push_bit(1'b0, "R8");
    push_bit(1'b1, "R8");
    while (!in_ready) @(negedge clk);
    push_char(8'h5A, 1'b0, "R8");
    @(negedge clk);
    in_valid = 1'b0;
    drain();
    // R9: freeze in the middle of a character
    send_char(8'h3C, 1'b0, "R9");
    repeat (3 * DIV) @(negedge clk);
    set_freeze(1'b1);
    repeat (5 * DIV) @(negedge clk);
    set_freeze(1'b0);
    drain();
    // R9: freeze during the last stop bit with the next character waiting
    send_char(8'hE1, 1'b0, "R9");
    while (exp_q.size() != 0) @(negedge clk);
    set_freeze(1'b1);
    fork
      send_char(8'h1E, 1'b0, "R9");
      begin
        repeat (4 * DIV) @(negedge clk);
        set_freeze(1'b0);
      end
    join
    drain();
    // R11: format change during a frame does not alter it
    send_char(8'hB2, 1'b0, "R11");
    cfg_len_code = 2'd0;
    cfg_par_en = 1'b1;
    cfg_two_stop = 1'b1;
    drain();
    cfg_len_code = 2'd3;
    cfg_par_en = 1'b0;
    cfg_two_stop = 1'b0;
    send_char(8'h4D, 1'b0, "R11");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule